// File: doc/BRIEF.md
# Programmable Interval Timer with Free-Running Divider

This block is a small timer peripheral for an 8-bit system bus. A first-stage prescaler turns the system clock into a base tick, one every 16 system cycles. Two counters run from that base tick. The first is a free-running 8-bit divider. The second is an 8-bit programmable counter, which steps only while its enable bit is set. Its step period is taken from a four-entry rate table.

When the programmable counter steps past 0xFF, it wraps to zero and sends a one-cycle request on the interrupt line. An external interrupt controller captures that request. Software reaches the four registers through a 2-bit offset inside the peripheral's window. Writes take effect at the clock edge. Reads are registered and appear one cycle after the offset is presented.

Top module: `sys_timer`

## Requirements
- R1: A base tick occurs once every 16 system clock cycles with no dropped cycles, so with rate select 01 the counter advances by exactly n over any window of 16·n cycles.
- R2: The divider (offset 0) advances by exactly one every 256 system cycles whether or not the counter is enabled, and wraps modulo 256, so it returns to the same value after 65536 cycles.
- R3: Any write to offset 0 sets the divider and its internal base-tick phase to zero. The next divider increment then comes between 241 and 256 cycles after the write.
- R4: Control bit 2 enables the counter. While the bit is 0, the counter value and its partial-period progress are both held. A disabled interval of whole base ticks therefore costs exactly those ticks and no more.
- R5: Control bits [1:0] give the counter period in base ticks: 00 gives 64, 01 gives 1, 10 gives 4, 11 gives 16. When a period completes, the period is subtracted from the progress count rather than the count being cleared.
- R6: A counter step from 0xFF leaves the counter at 0x00 and drives the interrupt output high for exactly one clock cycle, at the same edge.
- R7: Register offsets are 0 divider, 1 counter, 2 reload, 3 control. The read data at an edge shows the offset's value from before that edge. Control bits [7:3] read as 1.
- R8: The reload register (offset 2) stores and returns any byte written to it. It plays no part in overflow: the counter still becomes 0x00.
- R9: After reset, the divider, counter and reload registers read 0x00, control reads 0xF8, and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| addr_i | input | 2 | Register offset inside the window |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Registered read data for addr_i |
| irq_o | output | 1 | One-cycle timer overflow request |

## Verification
The counter is run at each of the four rate codes over windows that are whole multiples of the selected period. Because the table is not monotonic, a swapped or mis-decoded entry shows up as a wrong step count rather than a count that is merely scaled. The enable bit is turned off for exactly four base ticks in the middle of a window. The step count then shows whether partial-period progress was kept or lost, and two reads taken inside the gap show that the counter holds.

The divider is measured with the counter disabled, again after a clear write, and over a full 65536-cycle wrap. The overflow test preloads 0xFE with a non-zero reload value, which separates wrap-to-zero from reloading and also checks the width of the interrupt pulse.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_DIV = 2'd0,
    SEL_CNT = 2'd1,
    SEL_RLD = 2'd2,
    SEL_CTL = 2'd3
  } reg_sel_e;

  localparam int CTL_W   = 3;
  localparam int CTL_EN  = 2;
  localparam int RATE_W  = 2;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int SYS_PER_BASE = 16
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int PW = (SYS_PER_BASE > 1) ? $clog2(SYS_PER_BASE) : 1;
  localparam logic [PW-1:0] LAST = PW'(SYS_PER_BASE - 1);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      tick_o  <= 1'b0;
    end else if (phase_q == LAST) begin
      phase_q <= '0;
      tick_o  <= 1'b1;
    end else begin
      phase_q <= phase_q + 1'b1;
      tick_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_divider.sv
module tmr_divider #(
  parameter int DATA_W       = 8,
  parameter int BASE_PER_DIV = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] div_o
);
  localparam int SW = (BASE_PER_DIV > 1) ? $clog2(BASE_PER_DIV) : 1;
  localparam logic [SW-1:0] LAST = SW'(BASE_PER_DIV - 1);

  logic [SW-1:0] sub_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      sub_q <= '0;
      div_o <= '0;
    end else if (tick_i) begin
      if (sub_q == LAST) begin
        sub_q <= '0;
        div_o <= div_o + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PER0   = 64,
  parameter int PER1   = 1,
  parameter int PER2   = 4,
  parameter int PER3   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              ovf_o
);
  localparam int PMAX = max4(PER0, PER1, PER2, PER3);
  localparam int SW   = (PMAX > 1) ? $clog2(PMAX) : 1;
  localparam int PER_TAB [4] = '{PER0, PER1, PER2, PER3};

  logic [SW-1:0] sub_q;
  logic [SW:0]   per;
  logic [SW:0]   sub_inc;
  logic          step;
  logic          hit;

  always_comb begin
    per     = (SW+1)'(PER_TAB[rate_i]);
    sub_inc = {1'b0, sub_q} + 1'b1;
    step    = tick_i && en_i;
    hit     = step && (sub_inc >= per);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_q <= '0;
      cnt_o <= '0;
      ovf_o <= 1'b0;
    end else begin
      ovf_o <= 1'b0;
      if (step) begin
        sub_q <= hit ? SW'(sub_inc - per) : SW'(sub_inc);
      end
      if (load_i) begin
        cnt_o <= load_val_i;
      end else if (hit) begin
        cnt_o <= cnt_o + 1'b1;
        if (cnt_o == '1) ovf_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sys_timer.sv
module sys_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int SYS_PER_BASE = 16,
  parameter int BASE_PER_DIV = 16,
  parameter int RATE0_PER    = 64,
  parameter int RATE1_PER    = 1,
  parameter int RATE2_PER    = 4,
  parameter int RATE3_PER    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  localparam int PAD_W = DATA_W - CTL_W;

  logic              base_tick_w;
  logic [DATA_W-1:0] div_w;
  logic [DATA_W-1:0] cnt_w;
  logic [DATA_W-1:0] rld_q;
  logic [CTL_W-1:0]  ctl_q;
  logic              wr_div, wr_cnt, wr_rld, wr_ctl;

  always_comb begin
    wr_div = wr_en_i && (addr_i == SEL_DIV);
    wr_cnt = wr_en_i && (addr_i == SEL_CNT);
    wr_rld = wr_en_i && (addr_i == SEL_RLD);
    wr_ctl = wr_en_i && (addr_i == SEL_CTL);
  end

  tmr_prescale #(.SYS_PER_BASE(SYS_PER_BASE)) pre_i (
    .clk    (clk),
    .rst    (rst),
    .tick_o (base_tick_w)
  );

  tmr_divider #(.DATA_W(DATA_W), .BASE_PER_DIV(BASE_PER_DIV)) div_i (
    .clk    (clk),
    .rst    (rst),
    .tick_i (base_tick_w),
    .clr_i  (wr_div),
    .div_o  (div_w)
  );

  tmr_counter #(
    .DATA_W (DATA_W),
    .PER0   (RATE0_PER),
    .PER1   (RATE1_PER),
    .PER2   (RATE2_PER),
    .PER3   (RATE3_PER)
  ) cnt_i (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (base_tick_w),
    .en_i       (ctl_q[CTL_EN]),
    .rate_i     (ctl_q[RATE_W-1:0]),
    .load_i     (wr_cnt),
    .load_val_i (wr_data_i),
    .cnt_o      (cnt_w),
    .ovf_o      (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rld_q <= '0;
      ctl_q <= '0;
    end else begin
      if (wr_rld) rld_q <= wr_data_i;
      if (wr_ctl) ctl_q <= wr_data_i[CTL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o <= '0;
    end else begin
      case (addr_i)
        SEL_DIV: rd_data_o <= div_w;
        SEL_CNT: rd_data_o <= cnt_w;
        SEL_RLD: rd_data_o <= rld_q;
        default: rd_data_o <= {{PAD_W{1'b1}}, ctl_q};
      endcase
    end
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [1:0]        addr,
  input logic              irq,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] div,
  input logic              en,
  input logic              tick
);
  logic ld_cnt, ld_div;
  assign ld_cnt = wr_en && (addr == 2'd1);
  assign ld_div = wr_en && (addr == 2'd0);

  assert_tick_gap_R1: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  assert_div_step_R2: assert property (@(posedge clk) disable iff (rst)
    !ld_div |=> (div == $past(div) || div == DATA_W'($past(div) + 1'b1)));

  assert_div_clear_R3: assert property (@(posedge clk) disable iff (rst)
    ld_div |=> (div == '0));

  assert_hold_off_R4: assert property (@(posedge clk) disable iff (rst)
    (!en && !ld_cnt) |=> $stable(cnt));

  assert_cnt_step_R5: assert property (@(posedge clk) disable iff (rst)
    !ld_cnt |=> (cnt == $past(cnt) || cnt == DATA_W'($past(cnt) + 1'b1)));

  assert_irq_zero_R6: assert property (@(posedge clk) disable iff (rst)
    irq |-> (cnt == '0 && $past(cnt) == '1));

  assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
endmodule

bind sys_timer tmr_checker #(.DATA_W(DATA_W)) chk_i (
  .clk   (clk),
  .rst   (rst),
  .wr_en (wr_en_i),
  .addr  (addr_i),
  .irq   (irq_o),
  .cnt   (cnt_w),
  .div   (div_w),
  .en    (ctl_q[2]),
  .tick  (base_tick_w)
);

// File: tb/sys_timer_tb_top.sv
module sys_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  int irq_seen = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sys_timer dut_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en),
    .addr_i    (addr),
    .wr_data_i (wdata),
    .rd_data_o (rdata),
    .irq_o     (irq)
  );

  always @(negedge clk) if (irq) irq_seen++;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R9 irq low", {7'd0, irq}, 8'd0);
    peek(2'd0, v); chk("R9 divider", v, 8'h00);
    peek(2'd1, v); chk("R9 counter", v, 8'h00);
    peek(2'd2, v); chk("R9 reload", v, 8'h00);
    peek(2'd3, v); chk("R9 control", v, 8'hF8);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(2'd2, 8'hA5); peek(2'd2, v); chk("R8 reload readback", v, 8'hA5);
    wr(2'd3, 8'h02); peek(2'd3, v); chk("R7 control upper ones", v, 8'hFA);
  endtask

  task automatic t_div_rate();
    logic [7:0] a, b;
    wr(2'd3, 8'h00);
    peek(2'd0, a); idle(767); peek(2'd0, b);
    chk("R2 divider 768 cycles", b, 8'(a + 8'd3));
  endtask

  task automatic t_div_clear();
    logic [7:0] v;
    wr(2'd0, 8'h77);
    peek(2'd0, v); chk("R3 clear immediate", v, 8'h00);
    idle(149); peek(2'd0, v); chk("R3 still zero", v, 8'h00);
    idle(199); peek(2'd0, v); chk("R3 first step", v, 8'h01);
  endtask

  task automatic t_div_wrap();
    logic [7:0] a, b;
    peek(2'd0, a); idle(65535); peek(2'd0, b);
    chk("R2 divider wrap", b, a);
  endtask

  task automatic t_rate(input logic [1:0] sel, input int per, input int n);
    logic [7:0] a, b;
    wr(2'd3, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd3, {5'd0, 1'b1, sel});
    peek(2'd1, a); idle(16 * per * n - 1); peek(2'd1, b);
    chk($sformatf("R5 R1 rate code %0d", sel), b, 8'(a + 8'(n)));
  endtask

  task automatic t_hold();
    logic [7:0] a, pa, pb, b;
    wr(2'd3, 8'h02);
    wr(2'd1, 8'h00);
    wr(2'd3, 8'h06);
    peek(2'd1, a);
    wr(2'd3, 8'h02);
    idle(20); peek(2'd1, pa);
    idle(20); peek(2'd1, pb);
    idle(21);
    wr(2'd3, 8'h06);
    idle(126); peek(2'd1, b);
    chk("R4 held while off", pb, pa);
    chk("R4 phase kept", b, 8'(a + 8'd2));
  endtask

  task automatic t_ovf();
    logic [7:0] v;
    int guard;
    wr(2'd3, 8'h01);
    wr(2'd2, 8'h5A);
    wr(2'd1, 8'hFE);
    irq_seen = 0;
    wr(2'd3, 8'h05);
    guard = 0;
    while (irq_seen == 0 && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    chk("R6 irq raised", {7'd0, irq_seen != 0}, 8'd1);
    peek(2'd1, v); chk("R6 R8 counter zero after wrap", v, 8'h00);
    idle(40);
    chk("R6 single pulse", 8'(irq_seen), 8'd1);
    chk("R6 irq low after", {7'd0, irq}, 8'd0);
    wr(2'd3, 8'h00);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_div_rate();
    t_div_clear();
    t_rate(2'b01, 1, 10);
    t_rate(2'b10, 4, 5);
    t_rate(2'b11, 16, 3);
    t_rate(2'b00, 64, 2);
    t_hold();
    t_ovf();
    t_div_wrap();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule